// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test access port of a memory-style device. It follows the standard sixteen-state test-port state machine, clocked by `tck` and steered by `tms`. It holds a 3-bit instruction register and places one data register at a time between `tdi` and `tdo`. The data registers are a 1-bit bypass stage, a 32-bit identification register and a boundary-scan chain whose length is a parameter.

The boundary chain can only capture. On Capture-DR it takes a snapshot of the parallel `pinSample` vector. Data shifted into the chain never reaches any output. Two opcodes, the all-zeros code and a dedicated sample-with-tristate code, also raise `outHighZ`. The device core uses that signal to float its functional outputs.

A board-level tester drives the pins in the usual way: it walks the state machine with `tms`, presents `tdi` and samples `tdo`. An asynchronous active-low `trstN` forces the controller back to its idle-reset state.

Top module: `tapCtrl`

## Requirements
- R1: While `trstN` is low the controller is held in Test-Logic-Reset, with `tdoEn` low and `outHighZ` low. When `trstN` is released, IDCODE (3'b001) is the active instruction.
- R2: Under IDCODE, Capture-DR loads the parameter `ID_CODE` (default 32'h1A53_C0E5, bit 0 set). Shift-DR shifts it out least significant bit first.
- R3: Capture-IR loads 3'b001 and Shift-IR shifts it out least significant bit first. A new instruction becomes active only on Update-IR.
- R4: BYPASS (3'b111) inserts a single stage that loads 0 in Capture-DR. Each `tdi` bit therefore appears on `tdo` one shift later.
- R5: The reserved codes 3'b011, 3'b101 and 3'b110 behave exactly like BYPASS and leave `outHighZ` low.
- R6: SAMPLE (3'b100) captures `pinSample` into the boundary chain in Capture-DR and shifts it out with bit 0 first. `outHighZ` stays low.
- R7: Passing through Update-DR after shifting the boundary chain has no effect on any output. The next capture again reflects the live `pinSample`, not the shifted-in data.
- R8: EXTEST (3'b000) acts like SAMPLE, and in addition drives `outHighZ` high.
- R9: SAMPLE-Z (3'b010) drives `outHighZ` high and routes the boundary chain between `tdi` and `tdo`.
- R10: `outHighZ` changes only on the `tck` rising edge that leaves Update-IR, or on entry to Test-Logic-Reset.
- R11: Five consecutive `tms` highs reach Test-Logic-Reset from any state. This restores IDCODE and clears `outHighZ`.
- R12: `tdo` and `tdoEn` change on the falling edge of `tck`. `tdoEn` is high only during Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pinSample | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdoEn | output | 1 | High while `tdo` carries shift data |
| outHighZ | output | 1 | Forces the device's functional outputs to high impedance |

## Verification
The bench drives `tms` and `tdi` once per cycle and samples all outputs one nanosecond after the falling edge. By then the state reached at the preceding rising edge is visible on `tdoEn`, and the bit that register holds at position 0 is visible on `tdo`. A data scan shows its first bit as soon as Shift-DR is reached. Each further bit is due one cycle after the previous one.

`outHighZ` is checked in the cycle after Update-IR. It is also checked while still in Exit1-IR and in Update-IR, to confirm that it has not moved early. The falling-edge behaviour of `tdo` is checked by sampling once just after a rising edge, where the old bit must remain, and again after the following falling edge, where the new bit must appear.

// File: rtl/tapCtrlPkg.sv
package tapCtrlPkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic shiftIr;
    logic pickId;
    logic pickBsr;
    logic irBit;
  } tapStrobe_t;

endpackage

// File: rtl/tapFsm.sv
module tapFsm
  import tapCtrlPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapStrobe_t stb,
  output logic       highZ
);

  tapState_e state;
  tapState_e nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] activeIr;

  always_comb begin
    nextState = state;
    case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  // Instruction shift stage: Capture-IR loads the fixed pattern 3'b001
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= OP_IDCODE;
    end else if (state == ST_CAP_IR) begin
      irShift <= OP_IDCODE;
    end else if (state == ST_SH_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  // Active instruction and registered output-disable
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      activeIr <= OP_IDCODE;
      highZ    <= 1'b0;
    end else if (nextState == ST_RESET) begin
      activeIr <= OP_IDCODE;
      highZ    <= 1'b0;
    end else if (state == ST_UPD_IR) begin
      activeIr <= irShift;
      highZ    <= (irShift == OP_EXTEST) || (irShift == OP_SAMPLEZ);
    end
  end

  always_comb begin
    stb.captureDr = (state == ST_CAP_DR);
    stb.shiftDr   = (state == ST_SH_DR);
    stb.shiftIr   = (state == ST_SH_IR);
    stb.pickId    = (activeIr == OP_IDCODE);
    stb.pickBsr   = (activeIr == OP_EXTEST) || (activeIr == OP_SAMPLEZ) ||
                    (activeIr == OP_SAMPLE);
    stb.irBit     = irShift[0];
  end

  // R1 R11
  id_default_chk: assert property (@(posedge tck) disable iff (!trstN)
    state == ST_RESET |-> activeIr == OP_IDCODE);

  // R10
  hz_update_only_chk: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(highZ) |-> ($past(state) == ST_UPD_IR || state == ST_RESET));

  // R8
  hz_matches_ir_chk: assert property (@(posedge tck) disable iff (!trstN)
    highZ == ((activeIr == OP_EXTEST) || (activeIr == OP_SAMPLEZ)));

  // R11
  tms_escape_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == ST_RESET);

endmodule

// File: rtl/tapDataPath.sv
module tapDataPath
  import tapCtrlPkg::*;
#(
  parameter int                BSR_LEN = 16,
  parameter int                ID_W    = 32,
  parameter logic [ID_W-1:0]   ID_CODE = 32'h1A53_C0E5
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tapStrobe_t         stb,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdo,
  output logic               tdoEn
);

  logic               bypassReg;
  logic [ID_W-1:0]    idReg;
  logic [BSR_LEN-1:0] bsrReg;
  logic               serialBit;
  logic               pickBypass;

  assign pickBypass = !stb.pickId && !stb.pickBsr;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                          bypassReg <= 1'b0;
    else if (stb.captureDr)              bypassReg <= 1'b0;
    else if (stb.shiftDr && pickBypass)  bypassReg <= tdi;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                             idReg <= '0;
    else if (stb.captureDr && stb.pickId)   idReg <= ID_CODE;
    else if (stb.shiftDr && stb.pickId)     idReg <= {tdi, idReg[ID_W-1:1]};
  end

  // Boundary cells: capture only, no update stage
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shiftIn;
    if (i == BSR_LEN - 1) begin : g_last
      assign shiftIn = tdi;
    end else begin : g_mid
      assign shiftIn = bsrReg[i+1];
    end
    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)                            bsrReg[i] <= 1'b0;
      else if (stb.captureDr && stb.pickBsr) bsrReg[i] <= pinSample[i];
      else if (stb.shiftDr && stb.pickBsr)   bsrReg[i] <= shiftIn;
    end
  end

  always_comb begin
    if (stb.shiftIr)      serialBit = stb.irBit;
    else if (stb.pickId)  serialBit = idReg[0];
    else if (stb.pickBsr) serialBit = bsrReg[0];
    else                  serialBit = bypassReg;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialBit;
      tdoEn <= stb.shiftDr || stb.shiftIr;
    end
  end

  // R12
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (stb.shiftDr || stb.shiftIr));

  // R3
  single_phase_chk: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({stb.captureDr, stb.shiftDr, stb.shiftIr}));

endmodule

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapCtrlPkg::*;
#(
  parameter int              BSR_LEN = 16,
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A53_C0E5
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdo,
  output logic               tdoEn,
  output logic               outHighZ
);

  tapStrobe_t stb;

  tapFsm ctrl_i (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .tdi   (tdi),
    .stb   (stb),
    .highZ (outHighZ)
  );

  tapDataPath #(
    .BSR_LEN (BSR_LEN),
    .ID_W    (ID_W),
    .ID_CODE (ID_CODE)
  ) data_i (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .stb       (stb),
    .pinSample (pinSample),
    .tdo       (tdo),
    .tdoEn     (tdoEn)
  );

endmodule

// File: tb/tapCtrl_tb_top.sv
module tapCtrl_tb_top;

  localparam int          BSR_LEN = 16;
  localparam logic [31:0] ID_VAL  = 32'h1A53_C0E5;

  logic tck = 1'b0;
  logic trstN, tms, tdi;
  logic [BSR_LEN-1:0] pins;
  logic tdo, tdoEn, outHighZ;
  int   runCnt = 0;
  int   failCnt = 0;
  bit   done = 1'b0;

  always #5 tck = ~tck;

  tapCtrl #(.BSR_LEN(BSR_LEN), .ID_W(32), .ID_CODE(ID_VAL)) dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .pinSample(pins),
    .tdo(tdo), .tdoEn(tdoEn), .outHighZ(outHighZ)
  );

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] cap);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic testReset();
    logic [63:0] o;
    trstN = 1'b0; tms = 1'b1; tdi = 1'b0;
    #23;
    checkVal("R1 tdoEn in reset", {63'd0, tdoEn}, 64'd0);
    checkVal("R1 outHighZ in reset", {63'd0, outHighZ}, 64'd0);
    trstN = 1'b1;
    @(negedge tck); #1;
    step(1'b0, 1'b0);
    scanDr(32, 64'd0, o);
    checkVal("R1 R2 default IDCODE scan", o, {32'd0, ID_VAL});
  endtask

  task automatic testTdoEn();
    checkVal("R12 tdoEn idle", {63'd0, tdoEn}, 64'd0);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    checkVal("R12 tdoEn shift-dr", {63'd0, tdoEn}, 64'd1);
    step(1'b1, 1'b0);
    checkVal("R12 tdoEn exit1", {63'd0, tdoEn}, 64'd0);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic testBypass();
    logic [2:0] c; logic [63:0] o;
    loadIr(3'b111, c);
    checkVal("R3 capture-ir pattern", {61'd0, c}, 64'd1);
    scanDr(8, 64'hB2, o);
    checkVal("R4 bypass one-stage delay", o, {56'd0, 8'hB2 << 1});
  endtask

  task automatic testReserved();
    logic [2:0] c; logic [63:0] o;
    logic [2:0] codes [3] = '{3'b011, 3'b101, 3'b110};
    for (int k = 0; k < 3; k++) begin
      loadIr(codes[k], c);
      checkVal("R5 reserved no highZ", {63'd0, outHighZ}, 64'd0);
      scanDr(8, 64'h6D, o);
      checkVal("R5 reserved acts as bypass", o, {56'd0, 8'h6D << 1});
    end
  endtask

  task automatic testSample();
    logic [2:0] c; logic [63:0] o;
    pins = 16'hC3A5;
    loadIr(3'b100, c);
    checkVal("R6 sample no highZ", {63'd0, outHighZ}, 64'd0);
    scanDr(16, 64'h5A5A, o);
    checkVal("R6 sample capture", o, 64'hC3A5);
    checkVal("R7 highZ after update-dr", {63'd0, outHighZ}, 64'd0);
    checkVal("R7 tdoEn after update-dr", {63'd0, tdoEn}, 64'd0);
    pins = 16'h0F1E;
    scanDr(16, 64'h0, o);
    checkVal("R7 no preload, fresh capture", o, 64'h0F1E);
  endtask

  task automatic testExtest();
    logic [2:0] c; logic [63:0] o;
    pins = 16'h9137;
    loadIr(3'b000, c);
    checkVal("R8 extest highZ", {63'd0, outHighZ}, 64'd1);
    scanDr(16, 64'hFFFF, o);
    checkVal("R8 extest capture", o, 64'h9137);
  endtask

  task automatic testSampleZ();
    logic [2:0] c; logic [63:0] o;
    pins = 16'h4C2B;
    loadIr(3'b010, c);
    checkVal("R9 sample-z highZ", {63'd0, outHighZ}, 64'd1);
    scanDr(16, 64'h0, o);
    checkVal("R9 sample-z chain", o, 64'h4C2B);
  endtask

  task automatic testHzTiming();
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1);
    checkVal("R10 highZ held in exit1-ir", {63'd0, outHighZ}, 64'd1);
    step(1'b1, 1'b0);
    checkVal("R10 highZ held in update-ir", {63'd0, outHighZ}, 64'd1);
    step(1'b0, 1'b0);
    checkVal("R10 highZ cleared after update-ir", {63'd0, outHighZ}, 64'd0);
  endtask

  task automatic testEscape();
    logic [2:0] c; logic [63:0] o;
    loadIr(3'b010, c);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    checkVal("R11 highZ cleared by reset state", {63'd0, outHighZ}, 64'd0);
    step(1'b0, 1'b0);
    scanDr(32, 64'd0, o);
    checkVal("R11 IDCODE restored", o, {32'd0, ID_VAL});
  endtask

  task automatic testFallEdge();
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    checkVal("R12 first id bit", {63'd0, tdo}, {63'd0, ID_VAL[0]});
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    checkVal("R12 tdo held past rising edge", {63'd0, tdo}, {63'd0, ID_VAL[0]});
    @(negedge tck); #1;
    checkVal("R12 tdo moves on falling edge", {63'd0, tdo}, {63'd0, ID_VAL[1]});
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  initial begin
    pins = '0;
    testReset();
    testTdoEn();
    testBypass();
    testReserved();
    testSample();
    testExtest();
    testSampleZ();
    testHzTiming();
    testEscape();
    testFallEdge();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      runCnt++; failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

endmodule